// File: doc/BRIEF.md
# Translation Context Register Bank

This block holds the per-context programming and fault-reporting state of a small I/O address translation unit with up to eight contexts. Software reaches it through a plain 32-bit register port: a write strobe with address and data, and read data that follows the address combinationally in the same cycle. Only the non-secure alias window is decoded. It starts at byte 0x800, and each context owns a 64-byte slot inside it. Every other address reads as zero and ignores writes.

A translation engine, modelled as a stub in the testbench, reports faults to the bank as one-cycle events tagged with a context number. The bank sends each context's flush request to that engine as a busy level, and the engine ends the flush with a done pulse. Each context runs two small state machines.

The flush machine has two states, FL_IDLE and FL_BUSY:
- **start**: FL_IDLE moves to FL_BUSY when a control write has bit 1 set.
- **finish**: FL_BUSY returns to FL_IDLE on the context's done pulse.

The fault machine has two states, FT_CLEAN and FT_HELD:
- **capture**: FT_CLEAN moves to FT_HELD when an event arrives, or when a status write leaves an error flag set.
- **clear**: FT_HELD returns to FT_CLEAN when a status write leaves no error flag set.

In FT_HELD, further events only add flag bits. The fault address, error code and error level from the first event are kept.

Top module: `ttx_regbank`

## Requirements
- R1: After reset, every register of every context reads 0, and `irq`, `flush_busy` and `xlate_en` are all 0.
- R2: Context c occupies bytes 0x800+64c to 0x83F+64c, with these offsets:
  - control at 0x00;
  - table control (32 bits) at 0x08;
  - table base low (32 bits) at 0x10;
  - table base high (bits 7:0 only) at 0x14;
  - status at 0x20;
  - attribute index (32 bits) at 0x28;
  - fault address at 0x30.
  `bus_rdata` shows the addressed register in the same cycle.
- R3: The control register stores bits 0, 2, 3, 5:4, 16 and 17. Other bits read 0. Bit 0 drives `xlate_en[c]` and bit 2 is the interrupt enable.
- R4: A control write with bit 1 set starts a flush. From the next cycle until the cycle after a `flush_done[c]` pulse, control bit 1 reads 1 and `flush_busy[c]` is high. A done pulse while no flush is pending has no effect.
- R5: Status layout:
  - bit 0: translation fault;
  - bit 1: page fault;
  - bit 2: walk abort;
  - bit 4: multiple hit;
  - bits 10:8: error code;
  - bits 13:12: error level.
  A status write loads the written value masked to these bits.
- R6: An event on a context with no error flag set loads status from the event, replacing the previous code and level. It maps `ev_flags` bit 0 to status bit 0, bit 1 to bit 1, bit 2 to bit 2 and bit 3 to bit 4. It also loads `ev_code` into bits 10:8 and `ev_level` into bits 13:12, and captures `ev_addr` as the fault address. An event with all flags zero is ignored.
- R7: An event on a context that already has an error flag set ORs its flags into status. The code, level and fault address stay unchanged.
- R8: A status write that leaves no error flag set zeroes the fault address. A status write that leaves a flag set keeps it. Writes to the fault address are ignored.
- R9: When a status write and an event hit the same context in the same cycle, the write is applied first and the event is then merged into the result.
- R10: `irq` is high exactly when some context has interrupt enable set and at least one error flag set.
- R11: Any of the following reads 0 and ignores writes:
  - an address outside the window (including the secure bank below 0x800);
  - an address that is not word aligned;
  - an offset not listed in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, same cycle |
| ev_valid | input | 1 | Engine fault event strobe |
| ev_ctx | input | 3 | Context the event belongs to |
| ev_flags | input | 4 | {multi-hit, abort, page fault, translation fault} |
| ev_code | input | 3 | Error code of the event |
| ev_level | input | 2 | Error level of the event |
| ev_addr | input | 32 | Faulting address |
| flush_done | input | 8 | Per-context flush completion pulse |
| flush_busy | output | 8 | Per-context flush request / busy |
| xlate_en | output | 8 | Per-context translation enable |
| irq | output | 1 | Combined fault interrupt |

## Verification
The hardest situation to reach is a status write and a fault event landing on the same context in the same cycle. A zero write there must clear the flags before the new event captures a fresh address. A nonzero write there must instead keep the old address. A directed case lines both up on one clock edge. The random phase then draws writes and events independently, so such collisions recur, including on contexts with interrupts enabled and flushes pending.

// File: rtl/ttx_pkg.sv
package ttx_pkg;
    localparam int CTX_SPAN = 64;
    localparam int WIN_BASE = 'h800;

    localparam logic [31:0] CTRL_KEEP  = 32'h0003_003D;
    localparam logic [31:0] STAT_KEEP  = 32'h0000_3717;
    localparam logic [31:0] FLAG_BITS  = 32'h0000_0017;

    typedef enum logic [2:0] {
        SEL_NONE, SEL_CTRL, SEL_TCR, SEL_BLO, SEL_BHI, SEL_STAT, SEL_ATTR, SEL_FADDR
    } reg_sel_e;

    typedef enum logic { FL_IDLE, FL_BUSY } flush_st_e;
    typedef enum logic { FT_CLEAN, FT_HELD } fault_st_e;
endpackage

// File: rtl/ttx_decode.sv
module ttx_decode
    import ttx_pkg::*;
#(
    parameter int NUM_CTX = 8,
    parameter int ADDR_W  = 12,
    parameter int CTX_W   = 3
) (
    input  logic [ADDR_W-1:0]  addr,
    output logic [NUM_CTX-1:0] hit,
    output reg_sel_e           sel
);
    localparam logic [ADDR_W:0] WIN_LO = (ADDR_W+1)'(WIN_BASE);
    localparam logic [ADDR_W:0] WIN_HI = (ADDR_W+1)'(WIN_BASE + NUM_CTX * CTX_SPAN);

    logic             in_win;
    logic [CTX_W-1:0] idx;
    reg_sel_e         off_sel;

    always_comb begin
        in_win = ({1'b0, addr} >= WIN_LO) && ({1'b0, addr} < WIN_HI);
        idx    = CTX_W'(({1'b0, addr} - WIN_LO) >> 6);
        case (addr[5:0])
            6'h00:   off_sel = SEL_CTRL;
            6'h08:   off_sel = SEL_TCR;
            6'h10:   off_sel = SEL_BLO;
            6'h14:   off_sel = SEL_BHI;
            6'h20:   off_sel = SEL_STAT;
            6'h28:   off_sel = SEL_ATTR;
            6'h30:   off_sel = SEL_FADDR;
            default: off_sel = SEL_NONE;
        endcase
        sel = in_win ? off_sel : SEL_NONE;
        hit = '0;
        for (int i = 0; i < NUM_CTX; i++) begin
            if (in_win && (off_sel != SEL_NONE) && (idx == CTX_W'(i))) hit[i] = 1'b1;
        end
    end
endmodule

// File: rtl/ttx_ctx.sv
module ttx_ctx
    import ttx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  reg_sel_e    sel,
    input  logic [31:0] wdata,
    input  logic        ev_hit,
    input  logic [3:0]  ev_flags,
    input  logic [2:0]  ev_code,
    input  logic [1:0]  ev_level,
    input  logic [31:0] ev_addr,
    input  logic        flush_done,
    output logic [31:0] rdata,
    output logic        busy,
    output logic        xlate_en,
    output logic        irq_req
);
    flush_st_e   fl_st, fl_nx;
    fault_st_e   ft_st, ft_nx;
    logic [31:0] ctrl_q, tcr_q, blo_q, attr_q, stat_q, faddr_q;
    logic [7:0]  bhi_q;
    logic [31:0] stat_mid, stat_nx, faddr_nx, ev_vec, ev_info;
    logic        wr_stat, held_mid;

    // flush state machine: next state
    always_comb begin
        fl_nx = fl_st;
        unique case (fl_st)
            FL_IDLE: if (wr_en && sel == SEL_CTRL && wdata[1]) fl_nx = FL_BUSY;
            FL_BUSY: if (flush_done) fl_nx = FL_IDLE;
        endcase
    end

    // fault state machine: write first, then merge the event
    always_comb begin
        wr_stat  = wr_en && (sel == SEL_STAT);
        ev_vec   = {27'b0, ev_flags[3], 1'b0, ev_flags[2:0]};
        ev_info  = {18'b0, ev_level, 1'b0, ev_code, 8'b0};
        stat_mid = wr_stat ? (wdata & STAT_KEEP) : stat_q;
        held_mid = wr_stat ? ((wdata & FLAG_BITS) != '0) : (ft_st == FT_HELD);
        stat_nx  = stat_mid;
        faddr_nx = (wr_stat && !held_mid) ? '0 : faddr_q;
        if (ev_hit) begin
            if (held_mid) begin
                stat_nx = stat_mid | ev_vec;
            end else begin
                stat_nx  = ev_vec | ev_info;
                faddr_nx = ev_addr;
            end
        end
        ft_nx = ((stat_nx & FLAG_BITS) != '0) ? FT_HELD : FT_CLEAN;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fl_st <= FL_IDLE;
            ft_st <= FT_CLEAN;
        end else begin
            fl_st <= fl_nx;
            ft_st <= ft_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            tcr_q   <= '0;
            blo_q   <= '0;
            bhi_q   <= '0;
            attr_q  <= '0;
            stat_q  <= '0;
            faddr_q <= '0;
        end else begin
            if (wr_en && sel == SEL_CTRL) ctrl_q <= wdata & CTRL_KEEP;
            if (wr_en && sel == SEL_TCR)  tcr_q  <= wdata;
            if (wr_en && sel == SEL_BLO)  blo_q  <= wdata;
            if (wr_en && sel == SEL_BHI)  bhi_q  <= wdata[7:0];
            if (wr_en && sel == SEL_ATTR) attr_q <= wdata;
            stat_q  <= stat_nx;
            faddr_q <= faddr_nx;
        end
    end

    // outputs
    always_comb begin
        busy     = (fl_st == FL_BUSY);
        xlate_en = ctrl_q[0];
        irq_req  = ctrl_q[2] && (ft_st == FT_HELD);
        case (sel)
            SEL_CTRL:  rdata = ctrl_q | {30'b0, busy, 1'b0};
            SEL_TCR:   rdata = tcr_q;
            SEL_BLO:   rdata = blo_q;
            SEL_BHI:   rdata = {24'b0, bhi_q};
            SEL_STAT:  rdata = stat_q;
            SEL_ATTR:  rdata = attr_q;
            SEL_FADDR: rdata = faddr_q;
            default:   rdata = '0;
        endcase
    end

    p_flush_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_st == FL_BUSY && !flush_done) |=> (fl_st == FL_BUSY));
    p_flush_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_st == FL_BUSY && flush_done) |=> (fl_st == FL_IDLE));
    p_first_addr_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ft_st == FT_HELD && ev_hit && !wr_en) |=> (faddr_q == $past(faddr_q)));
    p_flags_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ft_st == FT_HELD && !wr_en) |=> (ft_st == FT_HELD));
    p_addr_zeroed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_STAT && (wdata & FLAG_BITS) == '0 && !ev_hit) |=> (faddr_q == '0));
    p_state_tracks_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ft_st == FT_HELD) == ((stat_q & FLAG_BITS) != '0));
endmodule

// File: rtl/ttx_regbank.sv
module ttx_regbank
    import ttx_pkg::*;
#(
    parameter int  NUM_CTX = 8,
    parameter int  ADDR_W  = 12,
    localparam int CTX_W   = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic               ev_valid,
    input  logic [CTX_W-1:0]   ev_ctx,
    input  logic [3:0]         ev_flags,
    input  logic [2:0]         ev_code,
    input  logic [1:0]         ev_level,
    input  logic [31:0]        ev_addr,
    input  logic [NUM_CTX-1:0] flush_done,
    output logic [NUM_CTX-1:0] flush_busy,
    output logic [NUM_CTX-1:0] xlate_en,
    output logic               irq
);
    logic [NUM_CTX-1:0] dec_hit;
    reg_sel_e           dec_sel;
    logic [31:0]        ctx_rd [NUM_CTX];
    logic [NUM_CTX-1:0] ctx_irq;

    ttx_decode #(.NUM_CTX(NUM_CTX), .ADDR_W(ADDR_W), .CTX_W(CTX_W)) u_dec (
        .addr(bus_addr),
        .hit (dec_hit),
        .sel (dec_sel)
    );

    for (genvar g = 0; g < NUM_CTX; g++) begin : g_ctx
        ttx_ctx u_ctx (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (bus_wr && dec_hit[g]),
            .sel       (dec_sel),
            .wdata     (bus_wdata),
            .ev_hit    (ev_valid && (ev_ctx == CTX_W'(g)) && (ev_flags != 4'b0)),
            .ev_flags  (ev_flags),
            .ev_code   (ev_code),
            .ev_level  (ev_level),
            .ev_addr   (ev_addr),
            .flush_done(flush_done[g]),
            .rdata     (ctx_rd[g]),
            .busy      (flush_busy[g]),
            .xlate_en  (xlate_en[g]),
            .irq_req   (ctx_irq[g])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_CTX; i++) begin
            if (dec_hit[i]) bus_rdata = bus_rdata | ctx_rd[i];
        end
        irq = |ctx_irq;
    end

    p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_hit == '0) |-> (bus_rdata == '0));
    p_one_ctx_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dec_hit));
endmodule

// File: tb/ttx_regbank_tb_top.sv
module ttx_regbank_tb_top;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ev_valid = 1'b0;
    logic [2:0]  ev_ctx = '0;
    logic [3:0]  ev_flags = '0;
    logic [2:0]  ev_code = '0;
    logic [1:0]  ev_level = '0;
    logic [31:0] ev_addr = '0;
    logic [N-1:0] flush_done = '0;
    logic [N-1:0] flush_busy, xlate_en;
    logic        irq;

    int vecs = 0;
    int errs = 0;

    logic [31:0] m_ctrl [N], m_tcr [N], m_blo [N], m_bhi [N];
    logic [31:0] m_stat [N], m_attr [N], m_faddr [N];
    logic        m_busy [N];

    always #5 clk = ~clk;

    ttx_regbank #(.NUM_CTX(N), .ADDR_W(12)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_valid(ev_valid),
        .ev_ctx(ev_ctx), .ev_flags(ev_flags), .ev_code(ev_code),
        .ev_level(ev_level), .ev_addr(ev_addr), .flush_done(flush_done),
        .flush_busy(flush_busy), .xlate_en(xlate_en), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // register codes: 0 ctrl 1 tcr 2 base-lo 3 base-hi 4 status 5 attr 6 fault addr
    function automatic bit dec(input logic [11:0] a, output int c, output int r);
        int ai = int'(a);
        c = 0; r = -1;
        if (ai < 'h800 || ai >= 'h800 + N * 64) return 1'b0;
        c = (ai - 'h800) / 64;
        case (a[5:0])
            6'h00: r = 0;
            6'h08: r = 1;
            6'h10: r = 2;
            6'h14: r = 3;
            6'h20: r = 4;
            6'h28: r = 5;
            6'h30: r = 6;
            default: return 1'b0;
        endcase
        return 1'b1;
    endfunction

    function automatic logic [31:0] exp_read(input logic [11:0] a);
        int c, r;
        if (!dec(a, c, r)) return 32'h0;
        case (r)
            0: return m_ctrl[c] | {30'b0, m_busy[c], 1'b0};
            1: return m_tcr[c];
            2: return m_blo[c];
            3: return m_bhi[c];
            4: return m_stat[c];
            5: return m_attr[c];
            default: return m_faddr[c];
        endcase
    endfunction

    function automatic logic exp_irq();
        logic x = 1'b0;
        for (int i = 0; i < N; i++)
            if (m_ctrl[i][2] && (m_stat[i] & 32'h17) != 0) x = 1'b1;
        return x;
    endfunction

    task automatic model_step();
        int c, r;
        bit v;
        logic nb [N];
        logic [31:0] mid, evv;
        bit held, ws;
        for (int i = 0; i < N; i++) nb[i] = m_busy[i] && !flush_done[i];
        v = bus_wr && dec(bus_addr, c, r);
        if (v) begin
            case (r)
                0: begin
                    m_ctrl[c] = bus_wdata & 32'h0003_003D;
                    if (!m_busy[c] && bus_wdata[1]) nb[c] = 1'b1;
                end
                1: m_tcr[c] = bus_wdata;
                2: m_blo[c] = bus_wdata;
                3: m_bhi[c] = {24'b0, bus_wdata[7:0]};
                5: m_attr[c] = bus_wdata;
                default: ;
            endcase
        end
        for (int i = 0; i < N; i++) begin
            ws   = v && r == 4 && c == i;
            mid  = ws ? (bus_wdata & 32'h3717) : m_stat[i];
            held = (mid & 32'h17) != 0;
            if (ws && !held) m_faddr[i] = 32'h0;
            if (ev_valid && int'(ev_ctx) == i && ev_flags != 0) begin
                evv = {27'b0, ev_flags[3], 1'b0, ev_flags[2:0]};
                if (held) mid = mid | evv;
                else begin
                    mid = evv | {18'b0, ev_level, 1'b0, ev_code, 8'b0};
                    m_faddr[i] = ev_addr;
                end
            end
            m_stat[i] = mid;
            m_busy[i] = nb[i];
        end
    endtask

    task automatic check_outs();
        logic [N-1:0] b, x;
        for (int i = 0; i < N; i++) begin
            b[i] = m_busy[i];
            x[i] = m_ctrl[i][0];
        end
        check("R10 irq", {31'b0, irq}, {31'b0, exp_irq()});
        check("R4 flush_busy", {24'b0, flush_busy}, {24'b0, b});
        check("R3 xlate_en", {24'b0, xlate_en}, {24'b0, x});
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        bus_wr = 1'b0;
        ev_valid = 1'b0;
        flush_done = '0;
        check_outs();
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        tick();
    endtask

    task automatic rd_lit(input string tag, input logic [11:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
        check(tag, bus_rdata, exp_read(a));
        tick();
    endtask

    task automatic event_in(input int c, input logic [3:0] f, input logic [2:0] code,
                            input logic [1:0] lvl, input logic [31:0] a);
        ev_valid = 1'b1; ev_ctx = 3'(c); ev_flags = f;
        ev_code = code; ev_level = lvl; ev_addr = a;
    endtask

    function automatic logic [11:0] rand_addr();
        logic [5:0] offs [7] = '{6'h00, 6'h08, 6'h10, 6'h14, 6'h20, 6'h28, 6'h30};
        if ($urandom_range(0, 7) == 0) return 12'($urandom);
        return 12'('h800 + $urandom_range(0, N - 1) * 64) + 12'(offs[$urandom_range(0, 6)]);
    endfunction

    initial begin
        #3_000_000;
        errs++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < N; i++) begin
            m_ctrl[i] = 0; m_tcr[i] = 0; m_blo[i] = 0; m_bhi[i] = 0;
            m_stat[i] = 0; m_attr[i] = 0; m_faddr[i] = 0; m_busy[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_outs();
        // R1 reset state
        rd_lit("R1 ctrl ctx0", 12'h800, 32'h0);
        rd_lit("R1 status ctx7", 12'h9E0, 32'h0);
        rd_lit("R1 faddr ctx4", 12'h930, 32'h0);

        // R2 map and R3 control mask
        wr(12'h8C8, 32'hA5A5_0001);
        wr(12'h954, 32'hFFFF_FF3C);
        wr(12'h810, 32'h1234_5678);
        wr(12'h868, 32'h0044_FF04);
        rd_lit("R2 table ctrl ctx3", 12'h8C8, 32'hA5A5_0001);
        rd_lit("R2 base hi ctx5", 12'h954, 32'h0000_003C);
        rd_lit("R2 base lo ctx0", 12'h810, 32'h1234_5678);
        rd_lit("R2 attr ctx1", 12'h868, 32'h0044_FF04);
        rd_lit("R2 ctx4 untouched", 12'h908, 32'h0);
        wr(12'h800, 32'hFFFF_FFFD);
        rd_lit("R3 ctrl mask", 12'h800, 32'h0003_003D);
        check("R3 xlate_en bit0", {31'b0, xlate_en[0]}, 32'h1);

        // R4 flush busy handshake
        wr(12'h840, 32'h2);
        rd_lit("R4 busy reads 1", 12'h840, 32'h2);
        tick(); tick();
        check("R4 still busy", {31'b0, flush_busy[1]}, 32'h1);
        flush_done = 8'h02;
        tick();
        check("R4 done clears", {31'b0, flush_busy[1]}, 32'h0);
        rd_lit("R4 bit1 reads 0", 12'h840, 32'h0);
        flush_done = 8'hFF;
        tick();
        check("R4 stray done", {24'b0, flush_busy}, 32'h0);

        // R6, R7, R8, R10 on context 2
        wr(12'h880, 32'h4);
        event_in(2, 4'b0001, 3'd4, 2'd2, 32'h1234_5000);
        tick();
        check("R10 irq raised", {31'b0, irq}, 32'h1);
        rd_lit("R6 status capture", 12'h8A0, 32'h0000_2401);
        rd_lit("R6 faddr capture", 12'h8B0, 32'h1234_5000);
        event_in(2, 4'b1000, 3'd1, 2'd1, 32'hDEAD_0000);
        tick();
        rd_lit("R7 flags merge", 12'h8A0, 32'h0000_2411);
        rd_lit("R7 faddr kept", 12'h8B0, 32'h1234_5000);
        wr(12'h8A0, 32'h0000_2411);
        rd_lit("R8 writeback keeps addr", 12'h8B0, 32'h1234_5000);
        wr(12'h8B0, 32'hFFFF_FFFF);
        rd_lit("R8 faddr write ignored", 12'h8B0, 32'h1234_5000);
        wr(12'h8A0, 32'h0);
        rd_lit("R8 cleared status", 12'h8A0, 32'h0);
        rd_lit("R8 cleared addr", 12'h8B0, 32'h0);
        check("R10 irq dropped", {31'b0, irq}, 32'h0);
        wr(12'h8A0, 32'hFFFF_FFFF);
        rd_lit("R5 status mask", 12'h8A0, 32'h0000_3717);
        event_in(2, 4'b0000, 3'd7, 2'd3, 32'h0BAD_0BAD);
        tick();
        rd_lit("R6 empty event ignored", 12'h8A0, 32'h0000_3717);

        // R9 collision of clearing write and event
        bus_addr = 12'h8A0; bus_wdata = 32'h0; bus_wr = 1'b1;
        event_in(2, 4'b0010, 3'd5, 2'd1, 32'hCAFE_0040);
        tick();
        rd_lit("R9 write then capture", 12'h8A0, 32'h0000_1502);
        rd_lit("R9 fresh addr", 12'h8B0, 32'hCAFE_0040);
        bus_addr = 12'h8A0; bus_wdata = 32'h0000_0004; bus_wr = 1'b1;
        event_in(2, 4'b0001, 3'd1, 2'd3, 32'h7777_0000);
        tick();
        rd_lit("R9 held write merge", 12'h8A0, 32'h0000_0005);
        rd_lit("R9 held addr kept", 12'h8B0, 32'hCAFE_0040);
        wr(12'h8A0, 32'h0);

        // R11 unmapped addresses
        wr(12'h000, 32'hFFFF_FFFF);
        rd_lit("R11 secure ignored", 12'h800, 32'h0003_003D);
        rd_lit("R11 secure reads 0", 12'h000, 32'h0);
        wr(12'h804, 32'hFFFF_FFFF);
        rd_lit("R11 hole reads 0", 12'h804, 32'h0);
        wr(12'h802, 32'h0);
        rd_lit("R11 unaligned ignored", 12'h800, 32'h0003_003D);
        wr(12'hA00, 32'hFFFF_FFFF);
        rd_lit("R11 past window", 12'hA00, 32'h0);

        // random phase
        for (int k = 0; k < 3000; k++) begin
            logic [11:0] ra;
            if ($urandom_range(0, 9) < 5) begin
                bus_addr = rand_addr(); bus_wdata = $urandom; bus_wr = 1'b1;
            end
            if ($urandom_range(0, 9) < 3)
                event_in($urandom_range(0, N - 1), 4'($urandom), 3'($urandom),
                         2'($urandom), $urandom);
            if ($urandom_range(0, 3) == 0) flush_done = N'($urandom);
            tick();
            ra = rand_addr();
            bus_addr = ra;
            #1;
            check("R2 random read", bus_rdata, exp_read(ra));
        end

        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule